// File: doc/BRIEF.md
# Bulk List Current Pointer Manager

This block holds the current-descriptor pointer that a USB host controller uses while it walks its bulk endpoint list. The list-walking engine reports two events: a descriptor has been served (with the next-pointer value it read from that descriptor), or the walk has reached the end of the list. The block moves the pointer forward after each served descriptor. It keeps the pointer unchanged between frames, so the walk resumes where it stopped.

At the end of the list, the block looks at a list-filled flag. If the flag is clear, nothing changes. If it is set, the head-pointer register is copied into the current pointer, and a one-cycle strobe asks the flag's owner to clear it. Host software may load the pointer through a write port, but only while the bulk list is disabled. The pointer output is always the live value. Pointers are 16-byte aligned, so the low four address bits are always zero.

Top module: `bulk_cur_ptr`

## Requirements
- R1: When `served_i` is high, `eol_i` is low and bits 31:4 of `next_ptr_i` are not all zero, `cur_ptr_o` equals `{next_ptr_i[31:4],4'b0}` after the next rising clock edge.
- R2: In a cycle with no engine event and no accepted software write, `cur_ptr_o` keeps its value, however many cycles pass.
- R3: At end of list (R10 defines when) with `list_filled_i` low, `cur_ptr_o` is unchanged and `filled_clr_o` stays low.
- R4: At end of list with `list_filled_i` high, `cur_ptr_o` becomes `{head_ptr_i[31:4],4'b0}` after the next edge. In that same cycle `filled_clr_o` is high for exactly that one cycle.
- R5: A software write (`sw_wr_i` high) while `list_en_i` is low loads `{sw_wdata_i[31:4],4'b0}` after the next edge.
- R6: A software write while `list_en_i` is high is ignored, and `cur_ptr_o` is unchanged.
- R7: While `rst_n` is low, `cur_ptr_o` is zero (end-of-list marker) and `filled_clr_o` is low.
- R8: Bits 3:0 of `cur_ptr_o` always read zero. Bits 3:0 of the head, next and write-data inputs have no effect.
- R9: When `eol_i` and `served_i` are both high in one cycle, the end-of-list handling applies and the advance is discarded.
- R10: End of list is signalled by `eol_i` high, or by `served_i` high with bits 31:4 of `next_ptr_i` all zero.
- R11: An engine event in the same cycle as a software write takes priority, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| head_ptr_i | input | 32 | Bulk list head pointer |
| list_filled_i | input | 1 | List-filled flag |
| list_en_i | input | 1 | Bulk list enable |
| served_i | input | 1 | Engine: present descriptor served |
| next_ptr_i | input | 32 | Engine: next-pointer field of the served descriptor |
| eol_i | input | 1 | Engine: end of list reached |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| cur_ptr_o | output | 32 | Live current pointer |
| filled_clr_o | output | 1 | One-cycle request to clear the list-filled flag |

## Verification
Any wrong decision in the block appears on `cur_ptr_o` or `filled_clr_o` on the first edge after the event that triggered it. A pointer that is lost or loaded by mistake stays visible until the next engine event or write overwrites it. The bench compares both outputs against a behavioural model after every edge. A wrong choice of priority, a reload that should not happen, or a write that should have been blocked is therefore reported in the cycle it occurs.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_ADV    = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_SWLOAD = 2'd3
  } bcp_act_e;
endpackage

// File: rtl/bcp_decide.sv
module bcp_decide
  import bcp_pkg::*;
(
  input  logic     served,
  input  logic     eol,
  input  logic     next_nz,
  input  logic     filled,
  input  logic     list_en,
  input  logic     sw_wr,
  output bcp_act_e act
);
  logic eol_eff;

  // R10: a served descriptor with a null next pointer ends the list
  assign eol_eff = eol | (served & ~next_nz);

  always_comb begin
    act = ACT_HOLD;
    if (eol_eff) begin
      // R9: end of list outranks advance
      act = filled ? ACT_RELOAD : ACT_HOLD;
    end else if (served) begin
      act = ACT_ADV;
    end else if (sw_wr && !list_en) begin
      // R11: engine events outrank software
      act = ACT_SWLOAD;
    end
  end
endmodule

// File: rtl/bcp_ptr_reg.sv
module bcp_ptr_reg
  import bcp_pkg::*;
#(
  parameter int PTR_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bcp_act_e         act,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] nxt,
  input  logic [PTR_W-1:0] wdat,
  output logic [PTR_W-1:0] ptr_q,
  output logic             clr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             clr_d;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    unique case (act)
      ACT_ADV:    begin ptr_d = nxt;  ptr_en = 1'b1; end
      ACT_RELOAD: begin ptr_d = head; ptr_en = 1'b1; end
      ACT_SWLOAD: begin ptr_d = wdat; ptr_en = 1'b1; end
      default:    begin ptr_d = ptr_q; ptr_en = 1'b0; end
    endcase
    clr_d = (act == ACT_RELOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
    end
  end

  // R4: the clear strobe accompanies a load of the head value
  p_clr_with_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (ptr_q == $past(head)));
endmodule

// File: rtl/bulk_cur_ptr.sv
module bulk_cur_ptr
  import bcp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_B = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] head_ptr_i,
  input  logic              list_filled_i,
  input  logic              list_en_i,
  input  logic              served_i,
  input  logic [ADDR_W-1:0] next_ptr_i,
  input  logic              eol_i,
  input  logic              sw_wr_i,
  input  logic [ADDR_W-1:0] sw_wdata_i,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic              filled_clr_o
);
  localparam int PTR_W = ADDR_W - ALIGN_B;

  bcp_act_e         act;
  logic             next_nz;
  logic [PTR_W-1:0] ptr_q;

  assign next_nz = |next_ptr_i[ADDR_W-1:ALIGN_B];

  bcp_decide i_decide (
    .served  (served_i),
    .eol     (eol_i),
    .next_nz (next_nz),
    .filled  (list_filled_i),
    .list_en (list_en_i),
    .sw_wr   (sw_wr_i),
    .act     (act)
  );

  bcp_ptr_reg #(.PTR_W(PTR_W)) i_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .head  (head_ptr_i[ADDR_W-1:ALIGN_B]),
    .nxt   (next_ptr_i[ADDR_W-1:ALIGN_B]),
    .wdat  (sw_wdata_i[ADDR_W-1:ALIGN_B]),
    .ptr_q (ptr_q),
    .clr_q (filled_clr_o)
  );

  // R8: low bits read as zero
  assign cur_ptr_o = {ptr_q, {ALIGN_B{1'b0}}};

  // R1: advance to the served descriptor's next pointer
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (served_i && !eol_i && next_nz) |=>
      (cur_ptr_o[ADDR_W-1:ALIGN_B] == $past(next_ptr_i[ADDR_W-1:ALIGN_B])));

  // R3: end of list with the flag clear leaves everything alone
  p_eol_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_i && !list_filled_i) |=> ($stable(cur_ptr_o) && !filled_clr_o));

  // R6: software writes are blocked while the list is enabled
  p_wr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && list_en_i && !served_i && !eol_i) |=> $stable(cur_ptr_o));

  // R4: the strobe fires only after a filled end of list
  p_clr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    filled_clr_o |-> $past(list_filled_i && (eol_i || (served_i && !next_nz))));
endmodule

// File: tb/test_bulk_cur_ptr.sv
module test_bulk_cur_ptr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] head_ptr_i, next_ptr_i, sw_wdata_i;
  logic        list_filled_i, list_en_i, served_i, eol_i, sw_wr_i;
  logic [31:0] cur_ptr_o;
  logic        filled_clr_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_ptr;
  logic        m_clr;

  always #2 clk = ~clk;

  bulk_cur_ptr i_bulk_cur_ptr (
    .clk(clk), .rst_n(rst_n), .head_ptr_i(head_ptr_i),
    .list_filled_i(list_filled_i), .list_en_i(list_en_i),
    .served_i(served_i), .next_ptr_i(next_ptr_i), .eol_i(eol_i),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
    .cur_ptr_o(cur_ptr_o), .filled_clr_o(filled_clr_o)
  );

  task automatic chk(input string rq, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act_v, exp_v);
    end
  endtask

  // behavioural reference: decide the expected outcome from the inputs
  task automatic step(input string rq);
    logic end_hit;
    logic [31:0] nxt_m;
    nxt_m   = next_ptr_i & 32'hFFFF_FFF0;
    end_hit = eol_i || (served_i && nxt_m == 0);
    m_clr   = 1'b0;
    if (end_hit) begin
      if (list_filled_i) begin
        m_ptr = head_ptr_i & 32'hFFFF_FFF0;
        m_clr = 1'b1;
      end
    end else if (served_i) m_ptr = nxt_m;
    else if (sw_wr_i && !list_en_i) m_ptr = sw_wdata_i & 32'hFFFF_FFF0;
    @(posedge clk);
    #1;
    chk(rq, cur_ptr_o, m_ptr);
    chk({rq, "_clr"}, {31'd0, filled_clr_o}, {31'd0, m_clr});
    chk("R8", {28'd0, cur_ptr_o[3:0]}, 32'd0);
    served_i = 0; eol_i = 0; sw_wr_i = 0;
  endtask

  initial begin
    #150000;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; head_ptr_i = 32'h0000_1238; next_ptr_i = 0; sw_wdata_i = 0;
    list_filled_i = 0; list_en_i = 0; served_i = 0; eol_i = 0; sw_wr_i = 0;
    m_ptr = 0; m_clr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", cur_ptr_o, 32'd0);
    chk("R7", {31'd0, filled_clr_o}, 32'd0);
    @(negedge clk); rst_n = 1;

    // R5: load while disabled, low bits dropped (R8)
    sw_wr_i = 1; sw_wdata_i = 32'h0000_A00F; step("R5");
    // R2: hold over idle cycles
    for (int i = 0; i < 5; i++) step("R2");
    // R6: write blocked while enabled
    list_en_i = 1; sw_wr_i = 1; sw_wdata_i = 32'h0000_BEE0; step("R6");
    // R1: advances
    served_i = 1; next_ptr_i = 32'h0000_2007; step("R1");
    served_i = 1; next_ptr_i = 32'hFFFF_FFF0; step("R1");
    // R3: end of list, flag clear
    eol_i = 1; step("R3");
    // R4: end of list, flag set
    list_filled_i = 1; head_ptr_i = 32'h0004_5675; eol_i = 1; step("R4");
    list_filled_i = 0; step("R4");
    // R9: eol beats advance
    served_i = 1; eol_i = 1; next_ptr_i = 32'h0000_7770; step("R9");
    list_filled_i = 1; head_ptr_i = 32'h0000_3330;
    served_i = 1; eol_i = 1; next_ptr_i = 32'h0000_7770; step("R9");
    list_filled_i = 0;
    // R10: null next pointer is end of list
    served_i = 1; next_ptr_i = 32'h0000_000C; step("R10");
    list_filled_i = 1; head_ptr_i = 32'h0000_9990;
    served_i = 1; next_ptr_i = 32'h0000_0000; step("R10");
    list_filled_i = 0;
    // R11: engine wins over software write while disabled
    list_en_i = 0;
    served_i = 1; next_ptr_i = 32'h0000_4440; sw_wr_i = 1; sw_wdata_i = 32'h0000_5550; step("R11");
    eol_i = 1; sw_wr_i = 1; sw_wdata_i = 32'h0000_6660; step("R11");
    // mixed stimulus against the reference model
    for (int i = 0; i < 400; i++) begin
      list_en_i     = $urandom_range(0, 1);
      list_filled_i = ($urandom_range(0, 3) == 0);
      served_i      = ($urandom_range(0, 2) == 0);
      eol_i         = ($urandom_range(0, 5) == 0);
      sw_wr_i       = ($urandom_range(0, 3) == 0);
      head_ptr_i    = $urandom;
      next_ptr_i    = ($urandom_range(0, 7) == 0) ? 32'h0000_0005 : $urandom;
      sw_wdata_i    = $urandom;
      step("R2");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule